// File: doc/BRIEF.md
# Cursor Overlay Mixer

This block lays a 32 by 32 two-colour pointer image over a stream of display pixels whose colours have already been looked up. Each incoming pixel arrives with its x and y screen coordinates and a 24-bit colour. The outgoing pixel keeps that colour unless the pointer is opaque at that screen position. Where the pointer is opaque, one of two overlay colours replaces it. The two overlay colours are supplied as inputs by an external palette.

Software shapes the pointer through a 32-bit register port that has fixed word offsets. That port holds the packed X/Y position, 32 opacity words and 32 image words. A further general control word is also reachable through the port. To hide the pointer, software parks it at a position far off-screen. Reset parks it there as well.

The output is registered once. The colour path and the valid flag travel together, so the stream leaves the block one clock after it enters.

Top module: `cursor_overlay`

## Requirements
- R1: Where the opacity bit for a pixel is 0, the output colour equals the input colour.
- R2: Where the opacity bit is 1, the output is `colorB` when the image bit is 1, and `colorA` when the image bit is 0.
- R3: Within a row word, bit 31 belongs to the pixel at the cursor X. The pixel at cursor X + k uses bit 31 − k.
- R4: A write to byte offset 0x8FC loads the cursor X from data bits 31:16 and the cursor Y from data bits 15:0.
- R5: A pixel row y is covered only when cursorY ≤ y < cursorY + 32, with unsigned comparisons and no wrap-around. Row r = y − cursorY uses the opacity word at offset 0x900 + 4r and the image word at offset 0x980 + 4r.
- R6: A pixel is replaced only when all of these hold: cursorX < activeWidth, x < activeWidth, and cursorX ≤ x < cursorX + 32.
- R7: After reset, both the cursor X and the cursor Y are 0xF000. All opacity and image words are 0, the control word is 0, and `outValid` is 0.
- R8: A read at offset 0x818 returns the last word written there with bit 25 forced to 1. A read at any other offset, including the position and row offsets, returns 0.
- R9: `outValid` and `outColor` follow `pixValid` and the mixed colour with exactly one clock of latency.
- R10: When `regWrEn` is low, no register changes, whatever the address and data are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte offset |
| regWData | input | 32 | Register write data |
| regRData | output | 32 | Register read data, combinational from `regAddr` |
| pixValid | input | 1 | Input pixel valid |
| pixX | input | 16 | Input pixel x coordinate |
| pixY | input | 16 | Input pixel y coordinate |
| pixColor | input | 24 | Input pixel colour |
| activeWidth | input | 16 | Number of visible pixels per line |
| colorA | input | 24 | Overlay colour used for opaque pixels with image bit 0 |
| colorB | input | 24 | Overlay colour used for opaque pixels with image bit 1 |
| outValid | output | 1 | Output pixel valid |
| outColor | output | 24 | Output pixel colour |

## Verification
On every cycle, the assertions check the following:
- the one-cycle valid pipeline;
- pass-through of pixels above the pointer, beyond the active width, or on rows whose opacity word is empty;
- the loading of the position register and the stability of the registers without a write strobe;
- the fixed shape of the read data.

The bench scenarios are the only way to show the rest:
- which of the two overlay colours is chosen;
- the MSB-leftmost bit order;
- the exact edges of the 32-row and 32-column window;
- clipping when the pointer starts beyond the active width;
- the absence of wrap-around when the pointer sits near the top of the coordinate range.

// File: rtl/curs_pkg.sv
package curs_pkg;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 32;
  localparam int COORD_W  = 16;
  localparam int CURS_N   = 32;
  localparam int IDX_W    = $clog2(CURS_N);

  localparam logic [ADDR_W-1:0] CTRL_OFS  = 12'h818;
  localparam logic [ADDR_W-1:0] POS_OFS   = 12'h8FC;
  localparam logic [ADDR_W-1:0] MASK_BASE = 12'h900;
  localparam logic [ADDR_W-1:0] IMG_BASE  = 12'h980;

  localparam logic [DATA_W-1:0] CTRL_FORCED = 32'h0200_0000;
  localparam logic [COORD_W-1:0] PARK_POS   = 16'hF000;

  typedef struct packed {
    logic [COORD_W-1:0] posX;
    logic [COORD_W-1:0] posY;
  } curs_pos_t;
endpackage

// File: rtl/curs_regs.sv
module curs_regs
  import curs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWData,
  output logic [DATA_W-1:0]    regRData,
  input  logic [IDX_W-1:0]     rowSel,
  output curs_pos_t            pos,
  output logic [DATA_W-1:0]    rowMask,
  output logic [DATA_W-1:0]    rowImg
);
  localparam int BLK_LSB = IDX_W + 2;

  logic [DATA_W-1:0] maskMem [CURS_N];
  logic [DATA_W-1:0] imgMem  [CURS_N];
  logic [DATA_W-1:0] ctrlReg;
  logic              wrPos, wrCtrl, wrMask, wrImg, aligned;
  logic [IDX_W-1:0]  wrRow;

  always_comb begin
    aligned = (regAddr[1:0] == 2'b00);
    wrRow   = regAddr[BLK_LSB-1:2];
    wrPos   = regWrEn && (regAddr == POS_OFS);
    wrCtrl  = regWrEn && (regAddr == CTRL_OFS);
    wrMask  = regWrEn && aligned &&
              (regAddr[ADDR_W-1:BLK_LSB] == MASK_BASE[ADDR_W-1:BLK_LSB]);
    wrImg   = regWrEn && aligned &&
              (regAddr[ADDR_W-1:BLK_LSB] == IMG_BASE[ADDR_W-1:BLK_LSB]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos.posX <= PARK_POS;
      pos.posY <= PARK_POS;
      ctrlReg  <= '0;
    end else begin
      if (wrPos) begin
        pos.posX <= regWData[DATA_W-1:COORD_W];
        pos.posY <= regWData[COORD_W-1:0];
      end
      if (wrCtrl) ctrlReg <= regWData;
    end
  end

  for (genvar r = 0; r < CURS_N; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskMem[r] <= '0;
        imgMem[r]  <= '0;
      end else begin
        if (wrMask && (wrRow == IDX_W'(r))) maskMem[r] <= regWData;
        if (wrImg  && (wrRow == IDX_W'(r))) imgMem[r]  <= regWData;
      end
    end
  end

  always_comb begin
    rowMask  = maskMem[rowSel];
    rowImg   = imgMem[rowSel];
    regRData = (regAddr == CTRL_OFS) ? (ctrlReg | CTRL_FORCED) : '0;
  end

  AST_POS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == POS_OFS) |=>
      (pos.posX == $past(regWData[DATA_W-1:COORD_W]) &&
       pos.posY == $past(regWData[COORD_W-1:0]))); // R4
  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> ($stable(pos.posX) && $stable(pos.posY))); // R10
  AST_CTRL_BIT_SET: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == CTRL_OFS) |-> regRData[25]); // R8
  AST_OTHER_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr != CTRL_OFS) |-> (regRData == '0)); // R8
endmodule

// File: rtl/curs_mix.sv
module curs_mix
  import curs_pkg::*;
#(
  parameter int COLOR_W = 24
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pixValid,
  input  logic [COORD_W-1:0]   pixX,
  input  logic [COORD_W-1:0]   pixY,
  input  logic [COLOR_W-1:0]   pixColor,
  input  logic [COORD_W-1:0]   activeWidth,
  input  logic [COLOR_W-1:0]   colorA,
  input  logic [COLOR_W-1:0]   colorB,
  input  curs_pos_t            pos,
  input  logic [DATA_W-1:0]    rowMask,
  input  logic [DATA_W-1:0]    rowImg,
  output logic [IDX_W-1:0]     rowSel,
  output logic                 outValid,
  output logic [COLOR_W-1:0]   outColor
);
  localparam logic [COORD_W-1:0] SPAN = COORD_W'(CURS_N);

  logic [COORD_W-1:0] dy, dx;
  logic               rowHit, colHit, opaque;
  logic [IDX_W-1:0]   bitIdx;
  logic [COLOR_W-1:0] mixColor;

  always_comb begin
    dy      = pixY - pos.posY;
    dx      = pixX - pos.posX;
    rowHit  = (pixY >= pos.posY) && (dy < SPAN);
    colHit  = (pos.posX < activeWidth) && (pixX < activeWidth) &&
              (pixX >= pos.posX) && (dx < SPAN);
    rowSel  = dy[IDX_W-1:0];
    bitIdx  = IDX_W'(CURS_N - 1) - dx[IDX_W-1:0];
    opaque  = rowHit && colHit && rowMask[bitIdx];
    if (opaque) mixColor = rowImg[bitIdx] ? colorB : colorA;
    else        mixColor = pixColor;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= pixValid;
  end

  always_ff @(posedge clk) outColor <= mixColor;

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> outValid); // R9
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> !outValid); // R9
  AST_CLIP_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (pixX >= activeWidth) |=> (outColor == $past(pixColor))); // R6
  AST_ABOVE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (pixY < pos.posY) |=> (outColor == $past(pixColor))); // R5
  AST_EMPTY_ROW_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (rowMask == '0) |=> (outColor == $past(pixColor))); // R1
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import curs_pkg::*;
#(
  parameter int COLOR_W = 24
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWData,
  output logic [DATA_W-1:0]   regRData,
  input  logic                pixValid,
  input  logic [COORD_W-1:0]  pixX,
  input  logic [COORD_W-1:0]  pixY,
  input  logic [COLOR_W-1:0]  pixColor,
  input  logic [COORD_W-1:0]  activeWidth,
  input  logic [COLOR_W-1:0]  colorA,
  input  logic [COLOR_W-1:0]  colorB,
  output logic                outValid,
  output logic [COLOR_W-1:0]  outColor
);
  curs_pos_t         pos;
  logic [IDX_W-1:0]  rowSel;
  logic [DATA_W-1:0] rowMask, rowImg;

  curs_regs i_regs (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWData (regWData),
    .regRData (regRData),
    .rowSel   (rowSel),
    .pos      (pos),
    .rowMask  (rowMask),
    .rowImg   (rowImg)
  );

  curs_mix #(.COLOR_W(COLOR_W)) i_mix (
    .clk         (clk),
    .rstN        (rstN),
    .pixValid    (pixValid),
    .pixX        (pixX),
    .pixY        (pixY),
    .pixColor    (pixColor),
    .activeWidth (activeWidth),
    .colorA      (colorA),
    .colorB      (colorB),
    .pos         (pos),
    .rowMask     (rowMask),
    .rowImg      (rowImg),
    .rowSel      (rowSel),
    .outValid    (outValid),
    .outColor    (outColor)
  );
endmodule

// File: tb/test_cursor_overlay.sv
`timescale 1ns/100ps
module test_cursor_overlay;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWData = '0;
  logic [31:0] regRData;
  logic        pixValid = 1'b0;
  logic [15:0] pixX = '0, pixY = '0;
  logic [23:0] pixColor = '0;
  logic [15:0] activeWidth = 16'd640;
  logic [23:0] colorA = 24'h11AA11, colorB = 24'hEE22EE;
  logic        outValid;
  logic [23:0] outColor;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // reference state
  logic [31:0] mMask [32];
  logic [31:0] mImg  [32];
  int          mX, mY;
  logic [31:0] mCtrl;

  always #2.5 clk = ~clk;

  cursor_overlay i_cursor_overlay (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWData(regWData), .regRData(regRData), .pixValid(pixValid),
    .pixX(pixX), .pixY(pixY), .pixColor(pixColor), .activeWidth(activeWidth),
    .colorA(colorA), .colorB(colorB), .outValid(outValid), .outColor(outColor)
  );

  function automatic logic [23:0] refColor(int x, int y, logic [23:0] c);
    int aw = activeWidth;
    if (y >= mY && y < mY + 32 && mX < aw && x < aw && x >= mX && x < mX + 32) begin
      int k = x - mX;
      int r = y - mY;
      if (mMask[r][31-k]) return mImg[r][31-k] ? colorB : colorA;
    end
    return c;
  endfunction

  task automatic report(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: reference computed from inputs at the edge, compared at the next falling edge
  task automatic step(string tag);
    logic        expV;
    logic [23:0] expC;
    @(posedge clk);
    expV = pixValid;
    expC = refColor(int'(pixX), int'(pixY), pixColor);
    if (regWrEn) begin
      if (regAddr == 12'h8FC) begin mX = int'(regWData[31:16]); mY = int'(regWData[15:0]); end
      else if (regAddr == 12'h818) mCtrl = regWData;
      else if (regAddr >= 12'h900 && regAddr <= 12'h97C && regAddr[1:0] == 0) mMask[(regAddr - 12'h900) >> 2] = regWData;
      else if (regAddr >= 12'h980 && regAddr <= 12'h9FC && regAddr[1:0] == 0) mImg[(regAddr - 12'h980) >> 2] = regWData;
    end
    @(negedge clk);
    report({tag, " valid"}, {31'd0, outValid}, {31'd0, expV});
    if (expV) report({tag, " color"}, {8'd0, outColor}, {8'd0, expC});
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
    regWrEn = 1'b1; regAddr = a; regWData = d;
    step(tag);
    regWrEn = 1'b0;
  endtask

  task automatic pix(int x, int y, logic [23:0] c, string tag);
    pixValid = 1'b1; pixX = 16'(x); pixY = 16'(y); pixColor = c;
    step(tag);
    pixValid = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    regAddr = a;
    #1;
    report(tag, regRData, exp);
  endtask

  initial begin
    mX = 32'hF000; mY = 32'hF000; mCtrl = '0;
    for (int r = 0; r < 32; r++) begin mMask[r] = '0; mImg[r] = '0; end
    repeat (3) @(negedge clk);
    report("R7 reset valid", {31'd0, outValid}, 32'd0);
    rstN = 1'b1;
    step("R7 idle");
    rd(12'h818, 32'h0200_0000, "R7 control after reset");
    pix(0, 0, 24'h123456, "R7 parked cursor");
    pix(16'hF000, 16'hF000, 24'h654321, "R7 parked beyond width");

    // control word and read map
    wr(12'h818, 32'h00AB_00CD, "R8 ctrl write");
    rd(12'h818, 32'h02AB_00CD, "R8 ctrl read");
    rd(12'h8FC, 32'h0, "R8 position reads zero");
    rd(12'h900, 32'h0, "R8 mask reads zero");

    // shape rows
    wr(12'h900, 32'h8000_0001, "R5 mask row0");
    wr(12'h980, 32'h8000_0000, "R5 image row0");
    wr(12'h97C, 32'hFFFF_FFFF, "R5 mask row31");
    wr(12'h9FC, 32'hAAAA_AAAA, "R5 image row31");

    // write with strobe low must not move the cursor
    regAddr = 12'h8FC; regWData = {16'd100, 16'd50};
    step("R10 no strobe");
    pix(100, 50, 24'h0F0F0F, "R10 cursor still parked");

    wr(12'h8FC, {16'd100, 16'd50}, "R4 position write");
    pix(100, 50, 24'h010203, "R2 R3 leftmost colorB");
    pix(131, 50, 24'h010203, "R2 R3 rightmost colorA");
    pix(101, 50, 24'h445566, "R1 transparent");
    pix(99, 50, 24'h445566, "R6 left of cursor");
    pix(132, 50, 24'h445566, "R6 right of cursor");
    pix(100, 49, 24'h778899, "R5 above window");
    pix(100, 81, 24'h778899, "R5 last row colorB");
    pix(101, 81, 24'h778899, "R3 last row colorA");
    pix(100, 82, 24'h778899, "R5 below window");
    pix(110, 60, 24'h202020, "R1 empty row");

    // back-to-back pixels
    pixValid = 1'b1;
    for (int x = 98; x < 136; x++) begin
      pixX = 16'(x); pixY = 16'd81; pixColor = 24'(x * 3);
      step("R9 streaming");
    end
    pixValid = 1'b0;
    step("R9 idle after stream");

    // clipping by the active width
    activeWidth = 16'd110;
    pix(109, 81, 24'h303030, "R6 inside width");
    pix(110, 81, 24'h303030, "R6 at width");
    activeWidth = 16'd100;
    pix(100, 81, 24'h303030, "R6 cursor at width");
    activeWidth = 16'd640;

    // near the top of the coordinate range: no wrap
    wr(12'h8FC, {16'd0, 16'hFFF0}, "R4 high Y");
    wr(12'h900, 32'hFFFF_FFFF, "R5 full row0");
    pix(0, 5, 24'h5A5A5A, "R5 no wrap");
    pix(0, 16'hFFF0, 24'h5A5A5A, "R5 top row drawn");
    wr(12'h8FC, {16'd630, 16'd10}, "R4 near right edge");
    pix(639, 10, 24'h0A0B0C, "R6 last visible");
    pix(640, 10, 24'h0A0B0C, "R6 first hidden");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule